// File: doc/BRIEF.md
# Single-Wire Parity Chunk Serializer

This block moves one chunk of 1 to 8 data bits across a single shared line that is pulled high when nobody drives it. A transmit side accepts a word and a bit count through a valid/ready handshake. It drives the selected bits most significant first and then an even parity bit. It then holds the line low for one more bit period and releases it, so the pull-up makes a rising edge that the two ends can use to realign.

A receive side is started by a one-cycle pulse that the caller lines up with the first bit. It samples the line once per bit period, half a period (rounded down) into each bit. It rebuilds the word, compares the received parity bit with the parity it computed, and reports the word, a one-cycle valid pulse, a mismatch flag and a running mismatch count.

The bit period is a count of clock cycles: a speed code picks a period in microseconds, and the parameter `CLK_MHZ` converts it to cycles. Each side latches the period when its chunk starts. Framing of packets, handshakes between the two ends and turning the line around are left to the caller.

Top module: `sw_parity_link`

## Requirements
- R1: While reset is low and after it is released: `line_oe`=0, `tx_ready`=1, `rx_valid`=0 and `rx_err_cnt`=0.
- R2: Once a chunk of n bits is accepted on the clock edge where `tx_valid` and `tx_ready` are both 1, bit period j (for j from 0 to n-1) drives `line_out`=`tx_data[n-1-j]` with `line_oe`=1. Bit period j covers cycles j*P+1 through (j+1)*P after the accepting edge.
- R3: Bit period n carries the parity bit. Its value is the XOR of the n data bits sent, starting from 0, so each 1 toggles it (even parity).
- R4: Bit period n+1 drives the line low (`line_oe`=1, `line_out`=0). In the cycle after it ends, `line_oe` returns to 0, `tx_ready` returns to 1 and the line floats high.
- R5: A bit count on `tx_len` or `rx_len` of 1 to 8 is used as given; 0 or any value above 8 is treated as 8. For a count below 8, the upper bits of `tx_data` are not sent.
- R6: The bit period P is CLK_MHZ times 4, 6, 12, 24, 36 or 48 for `speed_sel` 0 to 5; codes 6 and 7 give 6. P is taken from `speed_sel` when the chunk starts.
- R7: The receiver registers `line_in` at the end of cycle floor(P/2) of each bit period, counted from 1. Changes of `line_in` in the later cycles of a period have no effect.
- R8: After a receive started by `rx_start`, `rx_valid` is high for exactly one cycle, at cycle (n+1)*P+1 after the start edge. At that point `rx_data` holds the n received bits, the first one most significant, in bits n-1..0, with the upper bits 0.
- R9: With `rx_valid`, `rx_perr`=1 exactly when the received parity bit differs from the XOR of the received data bits, and `rx_err_cnt` then rises by one. Otherwise the count holds.
- R10: `tx_valid` while `tx_ready`=0 and `rx_start` while a receive is running are ignored: the chunk in flight and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_sel | input | 3 | Bit period code, latched per chunk |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter idle, request accepted |
| tx_data | input | 8 | Word to send, low n bits used |
| tx_len | input | 4 | Transmit bit count |
| line_oe | output | 1 | Drive enable for the shared line |
| line_out | output | 1 | Level driven when enabled |
| line_in | input | 1 | Sensed line level |
| rx_start | input | 1 | Start pulse, aligned with first bit |
| rx_len | input | 4 | Receive bit count |
| rx_valid | output | 1 | One-cycle result strobe |
| rx_data | output | 8 | Received word |
| rx_perr | output | 1 | Parity mismatch of the last chunk |
| rx_err_cnt | output | ERR_W | Count of parity mismatches |

## Verification
The bench loops the transmitter back into the receiver and flips the sensed line during chosen windows. A flip placed on exactly cycle floor(P/2) of a bit must corrupt that bit. A flip over the later half of a bit must not, so a receiver that samples one cycle late or at the end of a bit is caught. Flipping the parity sample alone, and flipping two adjacent data samples, separate a receiver that misses the mismatch from one that flags a double error it cannot see. Counts of 7, 3, 0 and 12, and speed codes including an out-of-range one, expose a wrong bit order, a missing length fold-back or a wrong period through the exact cycle of the tail release and of `rx_valid`. Requests issued mid-chunk would corrupt the line or shift the result if they were not ignored.

// File: rtl/swpl_pkg.sv
// swpl_pkg: shared constants, state encodings and helper functions for the
// single-wire parity chunk serializer. Assumes chunks of at most DATA_W bits.
package swpl_pkg;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned LEN_W   = $clog2(DATA_W + 1);
    localparam int unsigned SPEED_W = 3;
    localparam int unsigned MAX_US  = 48;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_DATA,
        TX_PAR,
        TX_TAIL
    } tx_state_t;

    // Bit period in microseconds for a speed code; unknown codes use 6 us.
    function automatic int unsigned period_us(input logic [SPEED_W-1:0] code);
        case (code)
            3'd0:    return 4;
            3'd1:    return 6;
            3'd2:    return 12;
            3'd3:    return 24;
            3'd4:    return 36;
            3'd5:    return 48;
            default: return 6;
        endcase
    endfunction

    // Fold a requested bit count into 1..DATA_W; 0 and oversize mean DATA_W.
    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] n);
        if (n == '0 || n > LEN_W'(DATA_W))
            return LEN_W'(DATA_W);
        return n;
    endfunction

endpackage

// File: rtl/swpl_bit_timer.sv
// swpl_bit_timer: counts clock cycles inside one bit period while active.
// The first active cycle has count 0. mid pulses in cycle floor(P/2) of the
// period (1-based), fin pulses in its last cycle. Assumes period >= 4.
module swpl_bit_timer #(
    parameter int unsigned PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [PW-1:0] period,
    output logic          mid,
    output logic          fin
);

    logic [PW-1:0] cnt;

    assign fin = active && (cnt == period - 1'b1);
    assign mid = active && (cnt == (period >> 1) - 1'b1);

    // Purpose: advance the in-period count, wrapping at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!active || fin)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/swpl_tx.sv
// swpl_tx: transmit side. Accepts a word and bit count when idle, then drives
// the bits first-most-significant, an even parity bit and one low tail
// period, after which it releases the line. Assumes an open-drain style pad
// where line_oe=0 lets a pull-up raise the line.
module swpl_tx
    import swpl_pkg::*;
#(
    parameter int unsigned CLK_MHZ = 16,
    parameter int unsigned PW      = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SPEED_W-1:0] speed_sel,
    input  logic               tx_valid,
    output logic               tx_ready,
    input  logic [DATA_W-1:0]  tx_data,
    input  logic [LEN_W-1:0]   tx_len,
    output logic               line_oe,
    output logic               line_out
);

    tx_state_t         state;
    logic [DATA_W-1:0] shreg;
    logic [LEN_W-1:0]  left;
    logic              par;
    logic [PW-1:0]     per_q;
    logic              fin;
    logic              mid_unused;

    logic [LEN_W-1:0]  n_c;
    logic [DATA_W-1:0] aligned_c;
    logic              par_next;

    assign tx_ready  = (state == TX_IDLE);
    assign n_c       = eff_len(tx_len);
    assign aligned_c = tx_data << (LEN_W'(DATA_W) - n_c);
    assign par_next  = par ^ line_out;

    swpl_bit_timer #(.PW(PW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state != TX_IDLE),
        .period (per_q),
        .mid    (mid_unused),
        .fin    (fin)
    );

    // Purpose: sequence data bits, parity bit and tail over the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TX_IDLE;
            shreg    <= '0;
            left     <= '0;
            par      <= 1'b0;
            per_q    <= PW'(period_us(SPEED_W'(1)) * CLK_MHZ);
            line_oe  <= 1'b0;
            line_out <= 1'b1;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (tx_valid) begin
                        state    <= TX_DATA;
                        shreg    <= aligned_c << 1;
                        line_out <= aligned_c[DATA_W-1];
                        left     <= n_c - 1'b1;
                        par      <= 1'b0;
                        per_q    <= PW'(period_us(speed_sel) * CLK_MHZ);
                        line_oe  <= 1'b1;
                    end
                end
                TX_DATA: begin
                    if (fin) begin
                        par <= par_next;
                        if (left == '0) begin
                            state    <= TX_PAR;
                            line_out <= par_next;
                        end else begin
                            line_out <= shreg[DATA_W-1];
                            shreg    <= shreg << 1;
                            left     <= left - 1'b1;
                        end
                    end
                end
                TX_PAR: begin
                    if (fin) begin
                        state    <= TX_TAIL;
                        line_out <= 1'b0;
                    end
                end
                default: begin
                    if (fin) begin
                        state    <= TX_IDLE;
                        line_oe  <= 1'b0;
                        line_out <= 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/swpl_rx.sv
// swpl_rx: receive side. Started by a pulse aligned with the first bit, it
// samples the line half a period into each bit, rebuilds the word, checks
// even parity and counts mismatches. Assumes the sender uses the same period.
module swpl_rx
    import swpl_pkg::*;
#(
    parameter int unsigned CLK_MHZ = 16,
    parameter int unsigned PW      = 10,
    parameter int unsigned ERR_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SPEED_W-1:0] speed_sel,
    input  logic               rx_start,
    input  logic [LEN_W-1:0]   rx_len,
    input  logic               line_in,
    output logic               rx_valid,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_perr,
    output logic [ERR_W-1:0]   rx_err_cnt
);

    logic              busy;
    logic [LEN_W-1:0]  nbits;
    logic [LEN_W-1:0]  idx;
    logic [DATA_W-1:0] word;
    logic              par;
    logic              pbit;
    logic [PW-1:0]     per_q;
    logic              mid;
    logic              fin;

    swpl_bit_timer #(.PW(PW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (busy),
        .period (per_q),
        .mid    (mid),
        .fin    (fin)
    );

    // Purpose: collect samples per bit and publish the result after parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            nbits      <= '0;
            idx        <= '0;
            word       <= '0;
            par        <= 1'b0;
            pbit       <= 1'b0;
            per_q      <= PW'(period_us(SPEED_W'(1)) * CLK_MHZ);
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_perr    <= 1'b0;
            rx_err_cnt <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!busy) begin
                if (rx_start) begin
                    busy  <= 1'b1;
                    nbits <= eff_len(rx_len);
                    idx   <= '0;
                    word  <= '0;
                    par   <= 1'b0;
                    per_q <= PW'(period_us(speed_sel) * CLK_MHZ);
                end
            end else begin
                if (mid) begin
                    if (idx != nbits) begin
                        word <= {word[DATA_W-2:0], line_in};
                        par  <= par ^ line_in;
                    end else begin
                        pbit <= line_in;
                    end
                end
                if (fin) begin
                    if (idx == nbits) begin
                        busy     <= 1'b0;
                        rx_valid <= 1'b1;
                        rx_data  <= word;
                        rx_perr  <= (par != pbit);
                        if (par != pbit)
                            rx_err_cnt <= rx_err_cnt + 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sw_parity_link.sv
// sw_parity_link: top of the single-wire parity chunk serializer. Holds one
// transmitter and one receiver that share a speed code; the caller resolves
// line_oe/line_out with a pull-up into the pad and feeds the pad to line_in.
module sw_parity_link
    import swpl_pkg::*;
#(
    parameter int unsigned CLK_MHZ = 16,
    parameter int unsigned ERR_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SPEED_W-1:0] speed_sel,
    input  logic               tx_valid,
    output logic               tx_ready,
    input  logic [DATA_W-1:0]  tx_data,
    input  logic [LEN_W-1:0]   tx_len,
    output logic               line_oe,
    output logic               line_out,
    input  logic               line_in,
    input  logic               rx_start,
    input  logic [LEN_W-1:0]   rx_len,
    output logic               rx_valid,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_perr,
    output logic [ERR_W-1:0]   rx_err_cnt
);

    localparam int unsigned PW = $clog2(MAX_US * CLK_MHZ + 1);

    swpl_tx #(.CLK_MHZ(CLK_MHZ), .PW(PW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_sel (speed_sel),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_len    (tx_len),
        .line_oe   (line_oe),
        .line_out  (line_out)
    );

    swpl_rx #(.CLK_MHZ(CLK_MHZ), .PW(PW), .ERR_W(ERR_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .speed_sel  (speed_sel),
        .rx_start   (rx_start),
        .rx_len     (rx_len),
        .line_in    (line_in),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_perr    (rx_perr),
        .rx_err_cnt (rx_err_cnt)
    );

endmodule

// File: rtl/swpl_checker.sv
// swpl_checker: temporal properties of sw_parity_link at its ports, bound
// into every instance of the top module.
module swpl_checker #(
    parameter int unsigned ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             line_oe,
    input logic             line_out,
    input logic             rx_valid,
    input logic             rx_perr,
    input logic [ERR_W-1:0] rx_err_cnt
);

    // R4: the line is driven exactly while a chunk is in flight.
    assert_drive_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready != line_oe);

    // R4: the cycle before release is a driven low.
    assert_tail_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> ($past(line_oe) && !$past(line_out)));

    // R10: driving starts only from an accepted request.
    assert_start_from_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> $past(tx_valid && tx_ready));

    // R8: the result strobe lasts one cycle.
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9: the mismatch count rises by one per flagged result.
    assert_err_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_perr) |-> (rx_err_cnt == ERR_W'($past(rx_err_cnt) + 1'b1)));

    // R9: the mismatch count holds otherwise.
    assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_perr) |-> $stable(rx_err_cnt));

endmodule

bind sw_parity_link swpl_checker #(.ERR_W(ERR_W)) u_swpl_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .line_oe    (line_oe),
    .line_out   (line_out),
    .rx_valid   (rx_valid),
    .rx_perr    (rx_perr),
    .rx_err_cnt (rx_err_cnt)
);

// File: tb/test_sw_parity_link.sv
module test_sw_parity_link;

    localparam int CLK_MHZ = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] speed_sel = 3'd0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [3:0] tx_len = 4'd8;
    logic       rx_start = 1'b0;
    logic [3:0] rx_len = 4'd8;
    logic       tx_ready, line_oe, line_out, line_in;
    logic       rx_valid, rx_perr;
    logic [7:0] rx_data;
    logic [7:0] rx_err_cnt;

    int  cyc = 0;
    int  base = 0;
    int  checks = 0;
    int  errors = 0;
    int  exp_err = 0;
    bit  done = 1'b0;
    logic flip_en = 1'b0;
    int  flip_lo = 0;
    int  flip_hi = 0;
    logic flip_now;

    typedef struct {
        logic [7:0] data;
        logic       perr;
        int         at;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb flip_now = flip_en && ((cyc - base) >= flip_lo) && ((cyc - base) <= flip_hi);
    assign line_in = (line_oe ? line_out : 1'b1) ^ flip_now;

    sw_parity_link #(.CLK_MHZ(CLK_MHZ), .ERR_W(8)) i_sw_parity_link (
        .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_len(tx_len),
        .line_oe(line_oe), .line_out(line_out), .line_in(line_in),
        .rx_start(rx_start), .rx_len(rx_len), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_err_cnt(rx_err_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int period_of(input logic [2:0] code);
        case (code)
            3'd0: return 4 * CLK_MHZ;
            3'd1: return 6 * CLK_MHZ;
            3'd2: return 12 * CLK_MHZ;
            3'd3: return 24 * CLK_MHZ;
            3'd4: return 36 * CLK_MHZ;
            3'd5: return 48 * CLK_MHZ;
            default: return 6 * CLK_MHZ;
        endcase
    endfunction

    task automatic wait_rel(input int t);
        while ((cyc - base) < t) @(negedge clk);
    endtask

    // Driver: send one chunk in loopback, push the expected result, check the line.
    task automatic send_chunk(input logic [7:0] data, input logic [3:0] len, input logic [2:0] spd,
                              input bit fl_en, input int fl_lo, input int fl_hi, input bit poke);
        int p, h, n;
        logic [8:0] sent;
        logic par, rpar, rbit, rxor;
        logic [7:0] word;
        bit covered;
        p = period_of(spd);
        h = p / 2;
        n = (len == 0 || len > 8) ? 8 : int'(len);
        par = 1'b0;
        sent = '0;
        for (int j = 0; j < n; j++) begin
            sent[j] = data[n-1-j];
            par = par ^ sent[j];
        end
        sent[n] = par;
        word = 8'h00;
        rxor = 1'b0;
        for (int j = 0; j < n; j++) begin
            covered = fl_en && (j*p + h >= fl_lo) && (j*p + h <= fl_hi);
            rbit = sent[j] ^ covered;
            word = {word[6:0], rbit};
            rxor = rxor ^ rbit;
        end
        covered = fl_en && (n*p + h >= fl_lo) && (n*p + h <= fl_hi);
        rpar = par ^ covered;

        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        speed_sel = spd; tx_data = data; tx_len = len; rx_len = len;
        tx_valid = 1'b1; rx_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        base = cyc - 1;
        tx_valid = 1'b0; rx_start = 1'b0;
        flip_lo = fl_lo; flip_hi = fl_hi; flip_en = fl_en;
        sb.push_back('{data: word, perr: (rxor != rpar), at: (n + 1) * p + 1});

        for (int j = 0; j <= n; j++) begin
            wait_rel(j * p + h);
            chk(line_oe == 1'b1, (j < n) ? "R2" : "R3", "line driven during bit", int'(line_oe), 1);
            chk(line_out == sent[j], (j < n) ? "R2" : "R3", $sformatf("bit %0d level", j), int'(line_out), int'(sent[j]));
            if (poke && j == 0) begin
                tx_valid = 1'b1; tx_data = ~data; rx_start = 1'b1;
                @(posedge clk);
                @(negedge clk);
                chk(tx_ready == 1'b0, "R10", "tx_ready while busy", int'(tx_ready), 0);
                tx_valid = 1'b0; rx_start = 1'b0;
            end
        end
        wait_rel((n + 1) * p + h);
        chk(line_oe == 1'b1 && line_out == 1'b0, "R4", "tail drives low", int'({line_oe, line_out}), 2);
        wait_rel((n + 2) * p);
        chk(line_oe == 1'b1, "R6", "still driving in last tail cycle", int'(line_oe), 1);
        wait_rel((n + 2) * p + 1);
        chk(line_oe == 1'b0 && tx_ready == 1'b1, "R4", "released and ready", int'({line_oe, tx_ready}), 1);
        chk(line_in == 1'b1, "R4", "line floats high", int'(line_in), 1);
        flip_en = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    // Monitor: pop the expected result on every strobe and compare.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8", "unexpected rx_valid", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(rx_data == it.data, "R8", "rx_data", int'(rx_data), int'(it.data));
                chk((cyc - base) == it.at, "R8", "rx_valid cycle", cyc - base, it.at);
                chk(rx_perr == it.perr, "R9", "rx_perr", int'(rx_perr), int'(it.perr));
                if (it.perr) exp_err++;
                chk(int'(rx_err_cnt) == exp_err, "R9", "rx_err_cnt", int'(rx_err_cnt), exp_err);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values
        chk(tx_ready == 1'b1 && line_oe == 1'b0, "R1", "idle in reset", int'({tx_ready, line_oe}), 2);
        chk(rx_valid == 1'b0 && rx_err_cnt == 8'd0, "R1", "rx idle in reset", int'(rx_err_cnt), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_ready == 1'b1 && line_oe == 1'b0 && line_in == 1'b1, "R1", "idle after reset", int'({tx_ready, line_oe, line_in}), 5);

        // R2 R3: plain loopback patterns, 8 and 7 bits
        send_chunk(8'hA5, 4'd8, 3'd0, 1'b0, 0, 0, 1'b0);
        send_chunk(8'hB5, 4'd7, 3'd0, 1'b0, 0, 0, 1'b0);
        send_chunk(8'hFF, 4'd8, 3'd0, 1'b0, 0, 0, 1'b0);
        send_chunk(8'h00, 4'd8, 3'd1, 1'b0, 0, 0, 1'b0);
        send_chunk(8'h6C, 4'd7, 3'd2, 1'b0, 0, 0, 1'b0);
        // R5: fold-back of counts
        send_chunk(8'h81, 4'd0, 3'd0, 1'b0, 0, 0, 1'b0);
        send_chunk(8'h3C, 4'd12, 3'd0, 1'b0, 0, 0, 1'b0);
        send_chunk(8'hFD, 4'd3, 3'd0, 1'b0, 0, 0, 1'b0);
        // R6: slowest code and an unknown code
        send_chunk(8'h5A, 4'd8, 3'd5, 1'b0, 0, 0, 1'b0);
        send_chunk(8'h96, 4'd7, 3'd6, 1'b0, 0, 0, 1'b0);
        // R7: flip only the sample cycle of data bit 2 (P=64, h=32)
        send_chunk(8'hC3, 4'd8, 3'd0, 1'b1, 2*64 + 32, 2*64 + 32, 1'b0);
        // R7: flip the later cycles of bit 4 only, no effect
        send_chunk(8'hC3, 4'd8, 3'd0, 1'b1, 4*64 + 33, 5*64, 1'b0);
        // R9: flip the parity sample of a 7-bit chunk
        send_chunk(8'h2B, 4'd7, 3'd0, 1'b1, 7*64 + 32, 7*64 + 32, 1'b0);
        // R9: two flipped data samples keep parity consistent
        send_chunk(8'h71, 4'd8, 3'd0, 1'b1, 1*64 + 32, 2*64 + 32, 1'b0);
        // R10: new requests during a chunk are ignored
        send_chunk(8'h4E, 4'd8, 3'd0, 1'b0, 0, 0, 1'b1);
        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R8", "all results seen", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=%0d expected=%0d", 150000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule